// File: doc/BRIEF.md
# Four-Lane Unrolled Wide Pseudo-Random Generator

This block produces a fresh 256-bit pseudo-random word each time it is stepped. It holds a state of four 64-bit words. One step runs four state updates back to back in combinational logic. Each update mixes the words with XOR, a left shift and rotations. The four states met along that chain each feed an output lane. A lane scrambles two of its state's words with an add, a rotate and a second add, and gives 64 bits of the result.

The result of a step is not visible at once. It is held as a pending value and reaches the registered output only when a commit strobe arrives. An abort strobe replaces the pending value with zero. Stepping does nothing until a seed has been loaded. A seed load replaces the whole state and enables stepping. The output port is the only interface to the stored value: there is no path that writes it directly.

Top module: `wide_prng`

## Requirements
- R1: After reset the output `rnd_o` is zero, the generator is not running and no pending value is held.
- R2: A step strobe before the first seed load changes neither the state nor the pending value, so a later commit leaves `rnd_o` unchanged.
- R3: A seed load replaces the state with `seed_i` and enables stepping. Word k of the state is `seed_i[64k+63:64k]`, and word 0 is the word called d below.
- R4: One state update takes a=word3, b=word2, c=word1 and d=word0 and gives new word3 = a^b^d, new word2 = a^b^c, new word1 = a^(b<<17, kept to 64 bits)^c, and new word0 = rotl(d,45)^rotl(b,45).
- R5: A step applies the update four times in a chain, S0 -> S1 -> S2 -> S3 -> S4, starting from the stored state S0, and stores S4 as the new state.
- R6: For lane i (i=0..3), m = (Si.word3 + Si.word0) mod 2^64 and lane_i = (rotl(m,23) + Si.word3) mod 2^64. The step result carries lane_i in bits 64i+63..64i and becomes the pending value.
- R7: `rnd_o` changes only on the clock edge that follows a commit strobe while a pending value is held. It then takes the pending value that was held before that edge, so a step and a commit in the same cycle commit the older pending value.
- R8: An abort strobe makes the pending value zero and marks it held. It takes priority over a step in the same cycle, so a commit after it drives `rnd_o` to zero.
- R9: When a seed load and a step arrive in the same cycle, only the seed load takes effect: the state becomes the seed and the pending value does not change.
- R10: A commit does not use up the pending value, so a second commit with no step in between leaves `rnd_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| seed_load_i | input | 1 | Load `seed_i` into the state and enable stepping |
| seed_i | input | 256 | Seed words, word k in bits 64k+63..64k |
| step_i | input | 1 | Run one four-update step |
| commit_i | input | 1 | Copy the pending value to the output |
| abort_i | input | 1 | Replace the pending value with zero |
| rnd_o | output | 256 | Registered committed random word |

## Verification
The bench keeps its own model of the update and lane equations. It runs dozens of seed and step sequences through that model, so a wrong shift distance, rotation or lane placement shows up as a mismatched committed word. It steps before any seed has been loaded: a design that ran from its built-in seed would commit a nonzero word there. It also hits colliding strobes. A seed load together with a step must not advance the state. A step together with a commit must commit the older word, and a design that passed the new word straight through would commit one step early. An abort must force a zero commit, a second commit without a new step must change nothing, and a design that cleared or advanced its pending value on commit fails those checks.

// File: rtl/wide_prng_pkg.sv
package wide_prng_pkg;

  localparam int unsigned WORD_W   = 64;
  localparam int unsigned ROT_UPD  = 45;
  localparam int unsigned SHL_UPD  = 17;
  localparam int unsigned ROT_MIX  = 23;

  typedef logic [WORD_W-1:0] word_t;
  // word 0 is "d", word 3 is "a"
  typedef logic [3:0][WORD_W-1:0] state_t;

  function automatic word_t rotl(input word_t x, input int unsigned n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction

  function automatic state_t update_fn(input state_t s);
    word_t a, b, c, d;
    state_t r;
    a = s[3];
    b = s[2];
    c = s[1];
    d = s[0];
    r[3] = a ^ b ^ d;
    r[2] = a ^ b ^ c;
    r[1] = a ^ (b << SHL_UPD) ^ c;
    r[0] = rotl(d, ROT_UPD) ^ rotl(b, ROT_UPD);
    return r;
  endfunction

  function automatic word_t lane_fn(input state_t s);
    word_t m;
    m = s[3] + s[0];
    return rotl(m, ROT_MIX) + s[3];
  endfunction

endpackage

// File: rtl/wide_prng_round.sv
module wide_prng_round
  import wide_prng_pkg::*;
(
  input  state_t s_i,
  output state_t s_o
);
  assign s_o = update_fn(s_i);
endmodule

// File: rtl/wide_prng_lane.sv
module wide_prng_lane
  import wide_prng_pkg::*;
(
  input  state_t s_i,
  output word_t  lane_o
);
  assign lane_o = lane_fn(s_i);
endmodule

// File: rtl/wide_prng_core.sv
module wide_prng_core
  import wide_prng_pkg::*;
#(
  parameter int unsigned NUM_LANES = 4,
  parameter state_t RESET_SEED = {64'h2cba89acbe4a07e9, 64'h25a4fe335d095f1e,
                                  64'h70aa1c59de6197ff, 64'h84ddfadaf7e1134d},
  localparam int unsigned OUT_W = NUM_LANES * WORD_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             seed_load_i,
  input  state_t           seed_i,
  input  logic             step_i,
  output logic             step_fire_o,
  output logic [OUT_W-1:0] step_word_o
);

  state_t state_q;
  logic   running_q;
  state_t chain [NUM_LANES+1];

  assign chain[0] = state_q;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_stage
    wide_prng_round u_round (
      .s_i (chain[g]),
      .s_o (chain[g+1])
    );
    wide_prng_lane u_lane (
      .s_i    (chain[g]),
      .lane_o (step_word_o[g*WORD_W +: WORD_W])
    );
  end

  // seed load wins over a step in the same cycle
  assign step_fire_o = step_i && running_q && !seed_load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= RESET_SEED;
      running_q <= 1'b0;
    end else if (seed_load_i) begin
      state_q   <= seed_i;
      running_q <= 1'b1;
    end else if (step_fire_o) begin
      state_q   <= chain[NUM_LANES];
    end
  end

  assert_seed_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_load_i |=> running_q && state_q == $past(seed_i));

  assert_chain_store_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && running_q && !seed_load_i |=> state_q == $past(chain[NUM_LANES]));

  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running_q && !seed_load_i |=> !running_q && $stable(state_q));

  assert_seed_prio_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_load_i && step_i |-> !step_fire_o);

endmodule

// File: rtl/wide_prng.sv
module wide_prng
  import wide_prng_pkg::*;
#(
  parameter int unsigned NUM_LANES = 4,
  localparam int unsigned OUT_W = NUM_LANES * WORD_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             seed_load_i,
  input  logic [255:0]     seed_i,
  input  logic             step_i,
  input  logic             commit_i,
  input  logic             abort_i,
  output logic [OUT_W-1:0] rnd_o
);

  logic             step_fire;
  logic [OUT_W-1:0] step_word;
  logic [OUT_W-1:0] pend_q;
  logic             pend_v_q;
  logic [OUT_W-1:0] out_q;

  wide_prng_core #(
    .NUM_LANES (NUM_LANES)
  ) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .seed_load_i (seed_load_i),
    .seed_i      (state_t'(seed_i)),
    .step_i      (step_i),
    .step_fire_o (step_fire),
    .step_word_o (step_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= '0;
      pend_v_q <= 1'b0;
      out_q    <= '0;
    end else begin
      if (abort_i) begin
        pend_q   <= '0;
        pend_v_q <= 1'b1;
      end else if (step_fire) begin
        pend_q   <= step_word;
        pend_v_q <= 1'b1;
      end
      if (commit_i && pend_v_q) begin
        out_q <= pend_q;
      end
    end
  end

  assign rnd_o = out_q;

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(rnd_o));

  assert_commit_old_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && pend_v_q |=> rnd_o == $past(pend_q));

  assert_abort_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> pend_v_q && pend_q == '0);

  assert_prio_pend_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_load_i && !abort_i |=> $stable(pend_q) && $stable(pend_v_q));

endmodule

// File: tb/tb_wide_prng.sv
`timescale 1ns/1ps
module tb_wide_prng;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         seed_load = 1'b0;
  logic [255:0] seed = '0;
  logic         step = 1'b0;
  logic         commit = 1'b0;
  logic         abort = 1'b0;
  logic [255:0] rnd;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wide_prng dut (
    .clk_i(clk), .rst_ni(rst_n), .seed_load_i(seed_load), .seed_i(seed),
    .step_i(step), .commit_i(commit), .abort_i(abort), .rnd_o(rnd)
  );

  // ---------------- reference model ----------------
  logic [63:0]  m_st [4];
  bit           m_run;
  logic [255:0] m_pend;
  bit           m_pv;
  logic [255:0] m_out;

  function automatic logic [63:0] rl(input logic [63:0] x, input int n);
    logic [127:0] t;
    t = {x, x} << n;
    return t[127:64];
  endfunction

  task automatic m_upd(inout logic [63:0] w [4]);
    logic [63:0] n3, n2, n1, n0;
    n3 = w[3] ^ w[2] ^ w[0];
    n2 = w[3] ^ w[2] ^ w[1];
    n1 = w[3] ^ {w[2][46:0], 17'd0} ^ w[1];
    n0 = rl(w[0], 45) ^ rl(w[2], 45);
    w[0] = n0; w[1] = n1; w[2] = n2; w[3] = n3;
  endtask

  task automatic m_step(output logic [255:0] word);
    logic [63:0] w [4];
    logic [63:0] mid;
    for (int k = 0; k < 4; k++) w[k] = m_st[k];
    word = '0;
    for (int i = 0; i < 4; i++) begin
      mid = w[3] + w[0];
      word[64*i +: 64] = rl(mid, 23) + w[3];
      m_upd(w);
    end
    for (int k = 0; k < 4; k++) m_st[k] = w[k];
  endtask

  // ---------------- scoreboard ----------------
  logic [255:0] exp_q [$];
  string        tag_q [$];
  logic         cmt_seen = 1'b0;

  always @(posedge clk) cmt_seen <= commit;

  always @(negedge clk) begin
    if (rst_n && cmt_seen) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: commit with no expected item, actual %h", rnd);
      end else begin
        logic [255:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rnd !== e) begin
          errors++;
          $display("FAIL %s: commit actual %h expected %h", t, rnd, e);
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one cycle of stimulus, model updated in step with it
  task automatic op(input bit ld, input logic [255:0] sd, input bit st,
                    input bit cm, input bit ab, input string tag);
    logic [255:0] word;
    @(negedge clk);
    seed_load = ld; seed = sd; step = st; commit = cm; abort = ab;
    if (cm && m_pv) m_out = m_pend;
    if (cm) begin exp_q.push_back(m_out); tag_q.push_back(tag); end
    if (ld) begin
      for (int k = 0; k < 4; k++) m_st[k] = sd[64*k +: 64];
      m_run = 1;
      if (ab) begin m_pend = '0; m_pv = 1; end
    end else begin
      if (st && m_run) begin
        m_step(word);
        if (!ab) begin m_pend = word; m_pv = 1; end
      end
      if (ab) begin m_pend = '0; m_pv = 1; end
    end
    @(posedge clk);
    #1;
    seed_load = 0; step = 0; commit = 0; abort = 0;
    if (!cm) chk({tag, "/R7 hold"}, rnd, m_out);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [255:0] s;
    m_run = 0; m_pv = 0; m_pend = '0; m_out = '0;
    for (int k = 0; k < 4; k++) m_st[k] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset output", rnd, '0);

    // R2: step before any seed, then commit
    op(0, '0, 1, 0, 0, "R2");
    op(0, '0, 0, 1, 0, "R2 commit before seed");

    // R3/R4/R5/R6: known seed, several steps
    s = {64'h0123456789abcdef, 64'hfedcba9876543210,
         64'h0f0f0f0f0f0f0f0f, 64'h8000000000000001};
    op(1, s, 0, 0, 0, "R3");
    for (int n = 0; n < 5; n++) begin
      op(0, '0, 1, 0, 0, "R5");
      op(0, '0, 0, 1, 0, "R4 R5 R6 chained step");
    end

    // zero seed and all-ones seed
    op(1, '0, 0, 0, 0, "R3");
    op(0, '0, 1, 1, 0, "R7 step with commit");
    op(0, '0, 0, 1, 0, "R6 zero seed");
    op(1, '1, 0, 0, 0, "R3");
    op(0, '0, 1, 0, 0, "R4");
    op(0, '0, 0, 1, 0, "R4 ones seed");

    // many random seeds and runs
    for (int r = 0; r < 30; r++) begin
      s = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      op(1, s, 0, 0, 0, "R3");
      for (int n = 0; n < 4; n++) begin
        op(0, '0, 1, (n % 2) == 1, 0, "R6 random run");
      end
      op(0, '0, 0, 1, 0, "R5 random run");
    end

    // R10: double commit
    op(0, '0, 1, 0, 0, "R10");
    op(0, '0, 0, 1, 0, "R10 first commit");
    op(0, '0, 0, 1, 0, "R10 second commit");

    // R8: abort, also colliding with a step
    op(0, '0, 1, 0, 1, "R8");
    op(0, '0, 0, 1, 0, "R8 commit after abort");
    op(0, '0, 1, 0, 0, "R8");
    op(0, '0, 0, 1, 0, "R8 step after abort");

    // R9: seed load with step in the same cycle
    s = {64'h1111111111111111, 64'h2222222222222222,
         64'h3333333333333333, 64'h4444444444444444};
    op(1, s, 1, 0, 0, "R9");
    op(0, '0, 0, 1, 0, "R9 pending unchanged");
    op(0, '0, 1, 0, 0, "R9");
    op(0, '0, 0, 1, 0, "R9 first step from seed");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R7: actual %0d unchecked commits expected 0", exp_q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule